// File: doc/BRIEF.md
# Timed Reset and Start Sequencer

This block runs the reset handshake between a device and the controller that manages it. An external reset request is accepted only when it has been held high long enough. When the request is released, a fixed internal initialisation interval runs, and an init-busy signal marks that interval. At the end of the interval the block raises a status-acknowledge bit. This tells the controller that the device is ready to be started.

The reset output goes high as soon as the reset request is seen. It stays high until the controller sends a start command while the acknowledge bit is set. A start command sent too early has no effect. A qualified reset that arrives during initialisation or after it throws away the progress so far, and the sequence begins again. A separate power-on reset puts the block in a defined state before the first request arrives.

Top module: `rst_start_seq`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it rises, `rst_out` is 1, `stat_ack` is 0 and `init_busy` is 0.
- R2: `rst_out` is 1 after the first rising clock edge at which `rst_in` is sampled 1. This holds for every pulse on `rst_in`, short ones included.
- R3: A reset request qualifies only if `rst_in` is sampled 1 on 8 consecutive edges. A shorter pulse starts no initialisation and leaves `stat_ack` and `init_busy` unchanged. The consecutive count clears whenever `rst_in` is sampled 0.
- R4: After a qualified request, `init_busy` rises at the first edge where `rst_in` is sampled 0. It then stays 1 for exactly 8191 cycles.
- R5: `stat_ack` rises at the same edge at which `init_busy` falls after a complete interval. It is never 1 while `init_busy` is 1.
- R6: `rst_out` stays 1 until `start_cmd` is sampled 1 together with `stat_ack` at 1 and `rst_in` at 0. `rst_out` is 0 after that edge.
- R7: A `start_cmd` sampled while `stat_ack` is 0 leaves `rst_out` at 1.
- R8: A request that qualifies during initialisation drops `init_busy` and keeps `stat_ack` at 0 from the 8th high edge onward. The next release then runs a full 8191-cycle interval.
- R9: A request that qualifies while `stat_ack` is 1 clears `stat_ack` at the 8th high edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_in | input | 1 | External reset request, active high |
| start_cmd | input | 1 | Start strobe from the management controller |
| rst_out | output | 1 | Reset output to the rest of the device, active high |
| stat_ack | output | 1 | Status acknowledge: initialisation has finished |
| init_busy | output | 1 | High while the initialisation interval runs |

## Verification
Every output is a register, so each result appears one edge after the input that causes it. `rst_out` follows the first high sample of `rst_in` by one edge. `init_busy` follows the first low sample after qualification by one edge. `stat_ack` rises 8191 edges after that. The bench drives inputs on the falling clock edge and samples after the next rising edge. It measures the busy interval by counting samples rather than waiting a fixed delay. The qualifying boundary is probed at the 7th and the 8th high edge.

// File: rtl/rss_pkg.sv
package rss_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_INIT  = 2'd2,
        PH_DONE  = 2'd3
    } rss_phase_e;

    typedef struct packed {
        rss_phase_e phase;
        logic       ack;
        logic       rst_out;
    } rss_state_t;

endpackage

// File: rtl/rss_pulse_qual.sv
module rss_pulse_qual #(
    parameter int MIN_PULSE = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_in,
    output logic qual_hit
);
    localparam int PW_W = $clog2(MIN_PULSE + 1);
    localparam logic [PW_W-1:0] CNT_TOP  = PW_W'(MIN_PULSE);
    localparam logic [PW_W-1:0] CNT_LAST = PW_W'(MIN_PULSE - 1);

    typedef struct packed {
        logic [PW_W-1:0] cnt;
    } pq_state_t;

    pq_state_t pq_d, pq_q;

    always_comb begin
        pq_d = pq_q;
        if (!rst_in) begin
            pq_d.cnt = '0;
        end else if (pq_q.cnt != CNT_TOP) begin
            pq_d.cnt = pq_q.cnt + 1'b1;
        end
        // fires once per pulse, on the edge that completes the minimum width
        qual_hit = rst_in && (pq_q.cnt == CNT_LAST);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pq_q <= '0;
        end else begin
            pq_q <= pq_d;
        end
    end

endmodule

// File: rtl/rss_init_timer.sv
module rss_init_timer #(
    parameter int INIT_CYCLES = 8191
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(INIT_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(INIT_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tm_state_t;

    tm_state_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (abort) begin
            tm_d.busy = 1'b0;
            tm_d.cnt  = '0;
        end else if (load) begin
            tm_d.busy = 1'b1;
            tm_d.cnt  = LOAD_VAL;
        end else if (tm_q.busy) begin
            if (tm_q.cnt == '0) begin
                tm_d.busy = 1'b0;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end
        busy = tm_q.busy;
        done = tm_q.busy && (tm_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

endmodule

// File: rtl/rst_start_seq.sv
module rst_start_seq
    import rss_pkg::*;
#(
    parameter int MIN_PULSE   = 8,
    parameter int INIT_CYCLES = 8191
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_in,
    input  logic start_cmd,
    output logic rst_out,
    output logic stat_ack,
    output logic init_busy
);
    logic qual_hit;
    logic tmr_load;
    logic tmr_abort;
    logic tmr_busy;
    logic tmr_done;

    rss_state_t st_d, st_q;

    rss_pulse_qual #(.MIN_PULSE(MIN_PULSE)) pq_i (
        .clk      (clk),
        .por_n    (por_n),
        .rst_in   (rst_in),
        .qual_hit (qual_hit)
    );

    rss_init_timer #(.INIT_CYCLES(INIT_CYCLES)) tm_i (
        .clk   (clk),
        .por_n (por_n),
        .load  (tmr_load),
        .abort (tmr_abort),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_abort = 1'b0;

        if (qual_hit) begin
            // a qualified request always restarts the handshake
            st_d.phase = PH_ARMED;
            st_d.ack   = 1'b0;
            tmr_abort  = 1'b1;
        end else begin
            case (st_q.phase)
                PH_ARMED: begin
                    if (!rst_in) begin
                        st_d.phase = PH_INIT;
                        tmr_load   = 1'b1;
                    end
                end
                PH_INIT: begin
                    if (tmr_done) begin
                        st_d.phase = PH_DONE;
                        st_d.ack   = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (rst_in) begin
            st_d.rst_out = 1'b1;
        end else if (st_q.rst_out && start_cmd && st_q.ack) begin
            st_d.rst_out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{phase: PH_IDLE, ack: 1'b0, rst_out: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out   = st_q.rst_out;
    assign stat_ack  = st_q.ack;
    assign init_busy = tmr_busy;

endmodule

// File: rtl/rst_start_seq_chk.sv
module rst_start_seq_chk #(
    parameter int INIT_CYCLES = 8191
) (
    input logic clk,
    input logic por_n,
    input logic rst_in,
    input logic start_cmd,
    input logic rst_out,
    input logic stat_ack,
    input logic init_busy
);
    localparam int RUN_W = $clog2(INIT_CYCLES + 2);

    logic [RUN_W-1:0] busy_run_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            busy_run_q <= '0;
        end else if (init_busy) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    // R2
    rst_out_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_in |=> rst_out);

    // R6
    rst_out_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_out && !(start_cmd && stat_ack && !rst_in)) |=> rst_out);

    // R7
    early_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_out && !stat_ack) |=> rst_out);

    // R5
    ack_busy_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(stat_ack && init_busy));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(stat_ack) |-> (busy_run_q == RUN_W'(INIT_CYCLES)));

    // R3
    busy_on_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(init_busy) |-> !$past(rst_in));

endmodule

bind rst_start_seq rst_start_seq_chk #(.INIT_CYCLES(INIT_CYCLES)) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .rst_in    (rst_in),
    .start_cmd (start_cmd),
    .rst_out   (rst_out),
    .stat_ack  (stat_ack),
    .init_busy (init_busy)
);

// File: tb/rst_start_seq_tb_top.sv
`timescale 1ns/1ps
module rst_start_seq_tb_top;
    localparam int INIT_N = 8191;

    logic clk = 1'b0;
    logic por_n;
    logic rst_in;
    logic start_cmd;
    logic rst_out;
    logic stat_ack;
    logic init_busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rst_start_seq dut_i (
        .clk       (clk),
        .por_n     (por_n),
        .rst_in    (rst_in),
        .start_cmd (start_cmd),
        .rst_out   (rst_out),
        .stat_ack  (stat_ack),
        .init_busy (init_busy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // counts the busy interval starting with the sample right after release
    task automatic measure_busy(string req);
        int n = 0;
        int ack_seen = 0;
        while (init_busy && n < INIT_N + 100) begin
            n++;
            if (stat_ack) ack_seen = 1;
            tick();
        end
        chk({req, " busy length"}, n, INIT_N);
        chk("R5 ack low during busy", ack_seen, 0);
        chk("R5 ack high at busy end", stat_ack, 1);
    endtask

    task automatic t_por();
        por_n = 1'b0; rst_in = 1'b0; start_cmd = 1'b0;
        tick(); tick();
        chk("R1 rst_out in por", rst_out, 1);
        chk("R1 ack in por", stat_ack, 0);
        chk("R1 busy in por", init_busy, 0);
        por_n = 1'b1;
        tick();
        chk("R1 rst_out after por", rst_out, 1);
        chk("R1 busy after por", init_busy, 0);
    endtask

    task automatic t_early_start();
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        chk("R7 start with ack low", rst_out, 1);
        tick();
        chk("R7 rst_out still high", rst_out, 1);
    endtask

    task automatic t_full_reset();
        rst_in = 1'b1;
        tick();
        chk("R2 rst_out after first high edge", rst_out, 1);
        for (int i = 2; i <= 8; i++) begin
            tick();
            chk("R3 no busy while held", init_busy, 0);
        end
        rst_in = 1'b0;
        tick();
        chk("R4 busy on release", init_busy, 1);
        chk("R5 ack low at release", stat_ack, 0);
        measure_busy("R4");
    endtask

    task automatic t_start();
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        chk("R6 rst_out released by start", rst_out, 0);
        tick();
        chk("R6 rst_out stays low", rst_out, 0);
    endtask

    task automatic t_short_pulse();
        rst_in = 1'b1;
        tick();
        chk("R2 rst_out on short pulse", rst_out, 1);
        for (int i = 2; i <= 7; i++) tick();
        chk("R3 ack kept at 7th edge", stat_ack, 1);
        rst_in = 1'b0;
        tick();
        chk("R3 short pulse no busy", init_busy, 0);
        chk("R3 short pulse keeps ack", stat_ack, 1);
        // counter must clear: another 7-edge pulse still does not qualify
        rst_in = 1'b1;
        for (int i = 1; i <= 7; i++) tick();
        rst_in = 1'b0;
        tick(); tick();
        chk("R3 counter cleared between pulses", init_busy, 0);
        chk("R3 ack after second short pulse", stat_ack, 1);
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        chk("R6 start after short pulse", rst_out, 0);
    endtask

    task automatic t_ack_clear();
        rst_in = 1'b1;
        for (int i = 1; i <= 7; i++) tick();
        chk("R9 ack before 8th edge", stat_ack, 1);
        tick();
        chk("R9 ack cleared at 8th edge", stat_ack, 0);
        rst_in = 1'b0;
        tick();
        chk("R4 busy after second release", init_busy, 1);
    endtask

    task automatic t_abort();
        for (int i = 0; i < 50; i++) tick();
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        chk("R7 start during init ignored", rst_out, 1);
        rst_in = 1'b1;
        for (int i = 1; i <= 7; i++) tick();
        chk("R3 busy kept before qualify", init_busy, 1);
        tick();
        chk("R8 busy dropped on qualify", init_busy, 0);
        chk("R8 ack low on qualify", stat_ack, 0);
        rst_in = 1'b0;
        tick();
        chk("R8 busy restarted", init_busy, 1);
        measure_busy("R8");
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        chk("R6 start after restart", rst_out, 0);
    endtask

    initial begin
        t_por();
        t_early_start();
        t_full_reset();
        t_start();
        t_short_pulse();
        t_ack_clear();
        t_abort();
        done = 1;
        summary();
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 60000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
                summary();
            end
        end
    end

endmodule